// File: doc/BRIEF.md
# Receive Byte Strobe Generator

This block derives the receive byte strobes that travel with 10-bit parallel receive words. It runs on a fast clock and advances once per serial bit, on a one-cycle bit-rate tick from the clock-recovery logic. A bit-phase counter splits the tick stream into words. At each word boundary it issues a one-cycle load enable for the parallel data register. The strobes rise halfway through each word, so the data loaded at the boundary is stable at every rising strobe edge.

There are two strobe modes, and the mode pin selects between them. In full-rate mode, strobe 0 toggles once per word and strobe 1 stays low. In half-rate mode, the two strobes run at half the word rate, in antiphase. Strobe 1 rises in even-numbered words and strobe 0 rises in odd-numbered words. The mode pin is sampled only at word boundaries.

A word aligner moves the boundary by requesting a stall. While the stall is in force, the bit-phase counter, the word parity and both strobe levels freeze. The current strobe phase is therefore stretched, and no short pulse is ever produced. A stall ends when the aligner reports that the new boundary is established. It also ends on its own once the maximum stretch has been swallowed.

Top module: `rx_strb_gen`

## Requirements
- R1: While rst_ni is low, strb0_o, strb1_o and word_ld_o are low. Reset selects full-rate mode, bit phase 0 and word parity even (word 0).
- R2: The bit phase advances from 0 to WORD_BITS-1 and wraps, on cycles where bit_tick_i is high and no stall is in force. word_ld_o is a one-cycle pulse in the cycle after the wrapping tick. Cycles without a tick change neither state nor outputs.
- R3: In full-rate mode, strbN_o follows the bit phase one clock later. strb0_o is high for phases WORD_BITS/2 to WORD_BITS-1 and low for the first half of the word. strb1_o is held low.
- R4: In half-rate mode, strb1_o is high in the second half of even words and in the first half of odd words, and strb0_o is its complement. Word parity counts completed words since reset, with word 0 even.
- R5: full_rate_i (1 = full rate, 0 = half rate) is sampled only on the tick that completes a word. Changing it mid-word has no effect until that word ends.
- R6: In a cycle with stall_i high, the bit tick is swallowed. Phase, parity and both strobe levels hold, and word_ld_o stays low. stall_i also arms a hold that outlasts it.
- R7: After stall_i drops, the hold stays in force until word_vld_i pulses with stall_i low. stall_i wins when both are high in the same cycle.
- R8: One stall episode swallows at most MAX_STRETCH ticks (default 20 bit times). Counting then resumes even if stall_i is still high, and a new episode needs stall_i and the hold to clear first.
- R9: Every strobe level lasts at least WORD_BITS/2 advancing bit ticks. A stall only lengthens a level.
- R10: A word_vld_i pulse with no stall or hold pending has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_tick_i | input | 1 | One-cycle enable per received serial bit |
| full_rate_i | input | 1 | Strobe mode: 1 full rate, 0 half rate (sampled at word end) |
| stall_i | input | 1 | Aligner request to freeze the strobes while the boundary moves |
| word_vld_i | input | 1 | Aligner pulse: new word boundary established, release hold |
| strb0_o | output | 1 | Strobe 0: full-rate strobe, or odd-word half-rate strobe |
| strb1_o | output | 1 | Strobe 1: even-word half-rate strobe, low in full rate |
| word_ld_o | output | 1 | Load enable for the parallel receive data register |

## Verification
The bench targets the following corner cases:

- **Mode pin flipped mid-word.** A design that samples the pin immediately would cut a strobe phase short or start the half-rate pair on the wrong word.
- **Stalls of several lengths, including one that outlasts the stretch limit.** A design that drops the cap would freeze forever. One that forgets the hold after stall_i falls would resume before the aligner is ready.
- **Stall and release arriving together, and a release with nothing pending.** A design with the wrong priority, or one that treats the release as a counter restart, would move the boundary or leave a sliver of a strobe pulse.
- **Sparse tick patterns.** These catch logic that counts clocks instead of bits.

// File: rtl/rx_strb_pkg.sv
package rx_strb_pkg;

  typedef enum logic {
    RATE_HALF = 1'b0,
    RATE_FULL = 1'b1
  } rate_e;

  // {strobe1, strobe0} for a given mode, word half and word parity
  function automatic logic [1:0] strb_levels(rate_e rate, logic upper, logic odd);
    logic [1:0] lv;
    if (rate == RATE_FULL) begin
      lv = {1'b0, upper};
    end else begin
      lv[1] = upper ^ odd;
      lv[0] = ~lv[1];
    end
    return lv;
  endfunction

endpackage

// File: rtl/rx_strb_hold.sv
module rx_strb_hold #(
  parameter int MAX_STRETCH = 20,
  localparam int CW = $clog2(MAX_STRETCH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          stall_i,
  input  logic          word_vld_i,
  output logic          frz_o,
  output logic [CW-1:0] hcnt_o
);

  logic          hold_q;
  logic [CW-1:0] hcnt_q;
  logic          req, cap;

  assign req   = stall_i | hold_q;
  assign cap   = (hcnt_q == CW'(MAX_STRETCH));
  assign frz_o = req & ~cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      hcnt_q <= '0;
    end else begin
      // stall wins over release; cap forces release once stall drops
      if (stall_i)                hold_q <= 1'b1;
      else if (word_vld_i || cap) hold_q <= 1'b0;

      if (!req)                   hcnt_q <= '0;
      else if (tick_i && frz_o)   hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign hcnt_o = hcnt_q;

endmodule

// File: rtl/rx_strb_phase.sv
module rx_strb_phase
  import rx_strb_pkg::*;
#(
  parameter int WORD_BITS = 10,
  localparam int PW = $clog2(WORD_BITS)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  frz_i,
  input  logic  full_rate_i,
  output rate_e rate_o,
  output logic  upper_o,
  output logic  odd_o,
  output logic  adv_o,
  output logic  ld_o
);

  logic [PW-1:0] phase_q;
  logic          odd_q, ld_q;
  rate_e         rate_q;
  logic          adv, wrap;

  assign adv  = tick_i & ~frz_i;
  assign wrap = adv & (phase_q == PW'(WORD_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      odd_q   <= 1'b0;
      rate_q  <= RATE_FULL;
      ld_q    <= 1'b0;
    end else begin
      ld_q <= wrap;
      if (adv) begin
        if (wrap) begin
          phase_q <= '0;
          odd_q   <= ~odd_q;
          rate_q  <= full_rate_i ? RATE_FULL : RATE_HALF;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assign rate_o  = rate_q;
  assign upper_o = (phase_q >= PW'(WORD_BITS / 2));
  assign odd_o   = odd_q;
  assign adv_o   = adv;
  assign ld_o    = ld_q;

endmodule

// File: rtl/rx_strb_out.sv
module rx_strb_out
  import rx_strb_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rate_e            rate_i,
  input  logic             upper_i,
  input  logic             odd_i,
  output logic [LANES-1:0] strb_o
);

  logic [1:0] lvl;

  assign lvl = strb_levels(rate_i, upper_i, odd_i);

  // registered per lane so the decode never reaches a pin
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= lvl[g];
    end
    assign strb_o[g] = q;
  end

endmodule

// File: rtl/rx_strb_gen.sv
module rx_strb_gen
  import rx_strb_pkg::*;
#(
  parameter int WORD_BITS   = 10,
  parameter int MAX_STRETCH = 2 * WORD_BITS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic full_rate_i,
  input  logic stall_i,
  input  logic word_vld_i,
  output logic strb0_o,
  output logic strb1_o,
  output logic word_ld_o
);

  localparam int CW = $clog2(MAX_STRETCH + 1);

  logic          frz, adv, upper, odd, full_q;
  logic [CW-1:0] hcnt;
  rate_e         rate_q;
  logic [1:0]    strb;

  rx_strb_hold #(.MAX_STRETCH(MAX_STRETCH)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (bit_tick_i),
    .stall_i    (stall_i),
    .word_vld_i (word_vld_i),
    .frz_o      (frz),
    .hcnt_o     (hcnt)
  );

  rx_strb_phase #(.WORD_BITS(WORD_BITS)) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (bit_tick_i),
    .frz_i       (frz),
    .full_rate_i (full_rate_i),
    .rate_o      (rate_q),
    .upper_o     (upper),
    .odd_o       (odd),
    .adv_o       (adv),
    .ld_o        (word_ld_o)
  );

  rx_strb_out #(.LANES(2)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rate_i  (rate_q),
    .upper_i (upper),
    .odd_i   (odd),
    .strb_o  (strb)
  );

  assign strb0_o = strb[0];
  assign strb1_o = strb[1];
  assign full_q  = (rate_q == RATE_FULL);

endmodule

// File: rtl/rx_strb_gen_chk.sv
module rx_strb_gen_chk #(
  parameter int WORD_BITS   = 10,
  parameter int MAX_STRETCH = 2 * WORD_BITS
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               tick_i,
  input logic                               stall_i,
  input logic                               s0_i,
  input logic                               s1_i,
  input logic                               ld_i,
  input logic                               full_i,
  input logic                               adv_i,
  input logic [$clog2(MAX_STRETCH+1)-1:0]   hcnt_i
);

  localparam int HALF = WORD_BITS / 2;
  localparam int CW   = $clog2(MAX_STRETCH + 1);

  logic       p0_q, p1_q, adv_d, capped;
  logic [7:0] r0_q, r1_q;

  assign capped = (hcnt_i == CW'(MAX_STRETCH));

  // advancing ticks spent in the current level of each strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p0_q  <= 1'b0;
      p1_q  <= 1'b0;
      adv_d <= 1'b0;
      r0_q  <= '0;
      r1_q  <= '0;
    end else begin
      p0_q  <= s0_i;
      p1_q  <= s1_i;
      adv_d <= adv_i;
      if (s0_i != p0_q)      r0_q <= {7'd0, adv_d};
      else if (r0_q != 8'hFF) r0_q <= r0_q + {7'd0, adv_d};
      if (s1_i != p1_q)      r1_q <= {7'd0, adv_d};
      else if (r1_q != 8'hFF) r1_q <= r1_q + {7'd0, adv_d};
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i ##1 !tick_i |=> $stable(s0_i) && $stable(s1_i)); // R2
  AST_IDLE_NO_LD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !ld_i); // R2
  AST_LD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> !ld_i); // R2
  AST_FULL_S1_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |=> !s1_i); // R3
  AST_HALF_ANTIPHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_i |=> (s0_i != s1_i)); // R4
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |-> $stable(full_i)); // R5
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !capped) ##1 (stall_i && !capped) |=> $stable(s0_i) && $stable(s1_i)); // R6
  AST_STALL_NO_LD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !capped) |=> !ld_i); // R6
  AST_STRETCH_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_i <= CW'(MAX_STRETCH)); // R8
  AST_S0_NO_SLIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s0_i != p0_q) |-> (r0_q >= 8'(HALF))); // R9
  AST_S1_NO_SLIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_i != p1_q) |-> (r1_q >= 8'(HALF))); // R9

endmodule

bind rx_strb_gen rx_strb_gen_chk #(
  .WORD_BITS   (WORD_BITS),
  .MAX_STRETCH (MAX_STRETCH)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (bit_tick_i),
  .stall_i (stall_i),
  .s0_i    (strb0_o),
  .s1_i    (strb1_o),
  .ld_i    (word_ld_o),
  .full_i  (full_q),
  .adv_i   (adv),
  .hcnt_i  (hcnt)
);

// File: tb/tb_rx_strb_gen.sv
`timescale 1ns/1ps
module tb_rx_strb_gen;

  localparam int WB   = 10;
  localparam int HALF = WB / 2;
  localparam int MAXS = 2 * WB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, full = 1'b1, stall = 1'b0, wv = 1'b0;
  logic s0, s1, ld;

  rx_strb_gen #(.WORD_BITS(WB), .MAX_STRETCH(MAXS)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bit_tick_i  (tick),
    .full_rate_i (full),
    .stall_i     (stall),
    .word_vld_i  (wv),
    .strb0_o     (s0),
    .strb1_o     (s1),
    .word_ld_o   (ld)
  );

  always #2.5 clk = ~clk;

  int    vecs = 0, errs = 0;
  string cur_req = "R1";

  // behavioural reference: bit index, word count, swallowed ticks
  int m_ph = 0, m_words = 0, m_sw = 0;
  bit m_full = 1, m_hold = 0, m_s0 = 0, m_s1 = 0, m_ld = 0, m_adv = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_words = 0; m_sw = 0; m_full = 1; m_hold = 0;
      m_s0 = 0; m_s1 = 0; m_ld = 0; m_adv = 0;
    end else begin : model
      bit second_half, req, cap, frz;
      second_half = (m_ph >= HALF);
      if (m_full) begin
        m_s0 = second_half; m_s1 = 0;
      end else begin
        m_s1 = second_half ^ (m_words % 2 == 1);
        m_s0 = !m_s1;
      end
      req   = stall || m_hold;
      cap   = (m_sw == MAXS);
      frz   = req && !cap;
      m_adv = tick && !frz;
      m_ld  = m_adv && (m_ph == WB - 1);
      if (!req) m_sw = 0;
      else if (tick && frz) m_sw++;
      if (stall) m_hold = 1;
      else if (wv || cap) m_hold = 0;
      if (m_adv) begin
        if (m_ph == WB - 1) begin
          m_ph = 0; m_words++; m_full = full;
        end else m_ph++;
      end
    end
  end

  bit prev0 = 0, prev1 = 0;
  int run0 = 0, run1 = 0;

  task automatic check_outputs();
    vecs++;
    if ({s0, s1, ld} !== {m_s0, m_s1, m_ld}) begin
      errs++;
      $display("FAIL %s t=%0t {s0,s1,ld} act=%b%b%b exp=%b%b%b",
               cur_req, $time, s0, s1, ld, m_s0, m_s1, m_ld);
    end
    if (rst_n) begin
      // R9: each level spans at least HALF advancing ticks
      if (s0 !== prev0) begin
        if (run0 < HALF) begin
          errs++;
          $display("FAIL R9 strb0 level run act=%0d exp>=%0d", run0, HALF);
        end
        run0 = 0;
      end
      if (s1 !== prev1) begin
        if (run1 < HALF) begin
          errs++;
          $display("FAIL R9 strb1 level run act=%0d exp>=%0d", run1, HALF);
        end
        run1 = 0;
      end
      run0 += int'(m_adv);
      run1 += int'(m_adv);
      prev0 = s0;
      prev1 = s1;
    end
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_outputs();
      tick = (gap <= 1) ? 1'b1 : ((i % gap) == 0);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check_outputs();
    rst_n = 1'b1;

    cur_req = "R3";  run(45, 1);
    cur_req = "R2";  run(60, 3);
    cur_req = "R5";  run(3, 1); full = 1'b0; run(33, 1);
    cur_req = "R4";  run(50, 1); run(40, 2);

    cur_req = "R6";  stall = 1'b1; run(4, 1); stall = 1'b0;
    cur_req = "R7";  run(6, 1); wv = 1'b1; run(1, 1); wv = 1'b0; run(15, 1);
    stall = 1'b1; wv = 1'b1; run(2, 1); stall = 1'b0; run(3, 1);
    wv = 1'b1; run(1, 1); wv = 1'b0; run(12, 1);

    cur_req = "R8";  stall = 1'b1; run(40, 1); stall = 1'b0; run(25, 1);
    stall = 1'b1; run(1, 1); stall = 1'b0; run(30, 1);

    cur_req = "R10"; wv = 1'b1; run(3, 1); wv = 1'b0; run(12, 1);
    cur_req = "R5";  run(7, 1); full = 1'b1; run(40, 1);
    cur_req = "R6";  stall = 1'b1; run(9, 3); stall = 1'b0;
    wv = 1'b1; run(1, 1); wv = 1'b0; run(25, 1);
    cur_req = "R3";  run(30, 2);

    finish_run();
  end

endmodule